// File: doc/BRIEF.md
# Configuration Address Translating Bridge

This block lets a host bus reach PCI configuration space through two address windows. The first window holds a 32-bit configuration index register. The second is a data window. Each access to the data window becomes one configuration request to a downstream target. The request carries a translated bus/device/function/register address, byte lane enables, write data and a direction flag. Read data from the target goes back to the host unchanged.

The translated address depends on the format of the index register, which is decided by two bits:
- When bit 31 is set, the index passes straight through.
- Otherwise, when bit 0 is set, the index is treated as a type-1 style address.
- Otherwise, the index is treated as a one-hot IDSEL select. The position of its lowest set bit becomes the binary device number.

The host side follows a request/done protocol. The host holds a request steady until the bridge pulses done for one cycle. A data-window access waits for as long as the target takes to complete its valid/ready handshake.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: After reset the index register reads as 0x00000000 and no target request is pending.
- R2: A write to the index window with h_size = 2 (4 bytes) or 3 (treated as 4 bytes) stores h_wdata. A later index-window read returns the stored value, one cycle after the request is seen.
- R3: An index-window write with h_size = 0 (1 byte) or 1 (2 bytes) leaves the index unchanged.
- R4: When index bit 31 is 1, t_addr equals the index with bits [1:0] replaced by data-window offset bits [1:0].
- R5: When index bit 31 is 0 and bit 0 is 1, t_addr equals the index with bits [2:0] replaced by offset bits [2:0].
- R6: When index bits 31 and 0 are both 0, the IDSEL format applies. The device number is the position, counted from bit 0 of the word, of the lowest set bit among index bits [31:11]. The translated address is {16'h0, device[4:0], index[10:8], index[7:3], offset[2:0]}.
- R7: In the IDSEL format with index bits [31:11] all zero, t_addr[31:11] are all ones. Bits [10:0] are built as in R6.
- R8: t_be comes from h_size and offset bits [1:0]:
  - size 0 gives a single lane, 1 << offset[1:0].
  - size 1 gives 4'b0011 when offset bit 1 is 0, and 4'b1100 when it is 1.
  - sizes 2 and 3 give 4'b1111.
- R9: h_wdata reaches t_wdata unchanged, and t_we follows h_we. On a read, t_rdata sampled at the handshake comes back unchanged on h_rdata.
- R10: A data-window access holds t_valid with a stable t_addr and t_be until t_ready. h_done pulses in the cycle after the handshake, so the access takes the target latency plus two cycles.
- R11: Index-window accesses never raise t_valid, and t_valid is low whenever no data-window access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_req | input | 1 | Host request, held until h_done |
| h_addr | input | 13 | Bit 12 selects the data window (1) or the index window (0); bits [11:0] are the offset |
| h_we | input | 1 | Host write (1) or read (0) |
| h_size | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| h_wdata | input | 32 | Host write data, lane-aligned little-endian |
| h_rdata | output | 32 | Host read data, valid while h_done is high |
| h_done | output | 1 | One-cycle completion pulse |
| t_valid | output | 1 | Configuration request valid |
| t_ready | input | 1 | Target accepts the request |
| t_addr | output | 32 | Translated configuration address |
| t_be | output | 4 | Byte lane enables |
| t_we | output | 1 | Configuration write |
| t_wdata | output | 32 | Configuration write data |
| t_rdata | input | 32 | Configuration read data |

## Verification
The assertions check four things on every cycle:
- The request holds stable while the target stalls.
- An index completion never overlaps a target request.
- The index changes only after a full-width index write, and a data completion always follows a handshake.
- The lane-enable count is legal, pass-through addresses keep their upper bits, and the all-ones device fill applies whenever no IDSEL bit is set.

Only the bench scenarios can show the exact translated address for each format. These include the choice of the lowest of several IDSEL bits, the per-size lane patterns, the data passing through unchanged, and the completion latency for each target delay.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int CFG_W  = 32;
  localparam int LANES  = CFG_W / 8;
  localparam int DEV_LO = 11;

  typedef enum logic [1:0] {
    FMT_RAW   = 2'd0,
    FMT_T1    = 2'd1,
    FMT_IDSEL = 2'd2
  } idx_fmt_e;

  // Format chosen by bit 31 first, then bit 0.
  function automatic idx_fmt_e idx_format(input logic [CFG_W-1:0] idx);
    if (idx[CFG_W-1])
      return FMT_RAW;
    else if (idx[0])
      return FMT_T1;
    else
      return FMT_IDSEL;
  endfunction

  // {found, position} of the lowest set bit in idx[31:11].
  function automatic logic [5:0] lowest_idsel(input logic [CFG_W-1:0] idx);
    logic [5:0] hit;
    hit = 6'd0;
    for (int b = CFG_W - 1; b >= DEV_LO; b--) begin
      if (idx[b]) hit = {1'b1, 5'(b)};
    end
    return hit;
  endfunction

  function automatic logic [CFG_W-1:0] xlate_cfg_addr(
      input logic [CFG_W-1:0] idx,
      input logic [2:0]       off);
    logic [5:0]       hit;
    logic [CFG_W-1:0] r;
    hit = lowest_idsel(idx);
    case (idx_format(idx))
      FMT_RAW: r = {idx[CFG_W-1:2], off[1:0]};
      FMT_T1:  r = {idx[CFG_W-1:3], off};
      default: begin
        if (hit[5])
          r = {16'h0000, hit[4:0], idx[10:8], idx[7:3], off};
        else
          r = {21'h1F_FFFF, idx[10:8], idx[7:3], off};
      end
    endcase
    return r;
  endfunction

  function automatic logic [LANES-1:0] lane_enables(
      input logic [1:0] sz,
      input logic [1:0] off);
    logic [LANES-1:0] be;
    case (sz)
      2'd0:    be = 4'b0001 << off;
      2'd1:    be = off[1] ? 4'b1100 : 4'b0011;
      default: be = 4'b1111;
    endcase
    return be;
  endfunction

endpackage

// File: rtl/cfgx_index_reg.sv
module cfgx_index_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] idx_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (wr_en)
      idx_q <= wr_data;
  end

endmodule

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
  import cfgx_pkg::*;
(
  input  logic [CFG_W-1:0] idx,
  input  logic [2:0]       off,
  input  logic [1:0]       size,
  output logic [CFG_W-1:0] xaddr,
  output logic [LANES-1:0] xbe,
  output idx_fmt_e         fmt
);

  always_comb begin
    fmt   = idx_format(idx);
    xaddr = xlate_cfg_addr(idx, off);
    xbe   = lane_enables(size, off[1:0]);
  end

endmodule

// File: rtl/cfgx_access_seq.sv
module cfgx_access_seq
  import cfgx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_req,
  input  logic             sel_data,
  input  logic             h_we,
  input  logic [1:0]       h_size,
  input  logic [CFG_W-1:0] h_wdata,
  input  logic [CFG_W-1:0] idx_q,
  input  logic [CFG_W-1:0] xaddr,
  input  logic [LANES-1:0] xbe,
  input  logic             t_ready,
  input  logic [CFG_W-1:0] t_rdata,
  output logic             idx_wr_en,
  output logic             idx_ack,
  output logic             dat_ack,
  output logic [CFG_W-1:0] h_rdata,
  output logic             t_valid,
  output logic [CFG_W-1:0] t_addr,
  output logic [LANES-1:0] t_be,
  output logic             t_we,
  output logic [CFG_W-1:0] t_wdata
);

  typedef enum logic [1:0] {S_IDLE, S_IDX_ACK, S_TGT, S_DAT_ACK} seq_state_e;

  seq_state_e st_q, st_d;
  logic       start_idx, start_dat, tgt_fire;

  assign start_idx = (st_q == S_IDLE) && h_req && !sel_data;
  assign start_dat = (st_q == S_IDLE) && h_req && sel_data;
  assign tgt_fire  = (st_q == S_TGT) && t_ready;
  assign idx_wr_en = start_idx && h_we && h_size[1];
  assign idx_ack   = (st_q == S_IDX_ACK);
  assign dat_ack   = (st_q == S_DAT_ACK);
  assign t_valid   = (st_q == S_TGT);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: begin
        if (start_idx) st_d = S_IDX_ACK;
        else if (start_dat) st_d = S_TGT;
      end
      S_TGT:     if (t_ready) st_d = S_DAT_ACK;
      default:   st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      h_rdata <= '0;
      t_addr  <= '0;
      t_be    <= '0;
      t_we    <= 1'b0;
      t_wdata <= '0;
    end else begin
      st_q <= st_d;
      if (start_idx) h_rdata <= idx_q;
      if (tgt_fire)  h_rdata <= t_rdata;
      if (start_dat) begin
        t_addr  <= xaddr;
        t_be    <= xbe;
        t_we    <= h_we;
        t_wdata <= h_wdata;
      end
    end
  end

endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
  import cfgx_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                h_req,
  input  logic [WIN_BITS:0]   h_addr,
  input  logic                h_we,
  input  logic [1:0]          h_size,
  input  logic [CFG_W-1:0]    h_wdata,
  output logic [CFG_W-1:0]    h_rdata,
  output logic                h_done,
  output logic                t_valid,
  input  logic                t_ready,
  output logic [CFG_W-1:0]    t_addr,
  output logic [LANES-1:0]    t_be,
  output logic                t_we,
  output logic [CFG_W-1:0]    t_wdata,
  input  logic [CFG_W-1:0]    t_rdata
);

  logic             sel_data;
  logic             idx_wr_en, idx_ack, dat_ack;
  logic [CFG_W-1:0] idx_q, xaddr;
  logic [LANES-1:0] xbe;
  idx_fmt_e         fmt;

  assign sel_data = h_addr[WIN_BITS];
  assign h_done   = idx_ack | dat_ack;

  cfgx_index_reg #(.W(CFG_W)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (idx_wr_en),
    .wr_data (h_wdata),
    .idx_q   (idx_q)
  );

  cfgx_addr_xlate u_xlate (
    .idx   (idx_q),
    .off   (h_addr[2:0]),
    .size  (h_size),
    .xaddr (xaddr),
    .xbe   (xbe),
    .fmt   (fmt)
  );

  cfgx_access_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .h_req     (h_req),
    .sel_data  (sel_data),
    .h_we      (h_we),
    .h_size    (h_size),
    .h_wdata   (h_wdata),
    .idx_q     (idx_q),
    .xaddr     (xaddr),
    .xbe       (xbe),
    .t_ready   (t_ready),
    .t_rdata   (t_rdata),
    .idx_wr_en (idx_wr_en),
    .idx_ack   (idx_ack),
    .dat_ack   (dat_ack),
    .h_rdata   (h_rdata),
    .t_valid   (t_valid),
    .t_addr    (t_addr),
    .t_be      (t_be),
    .t_we      (t_we),
    .t_wdata   (t_wdata)
  );

endmodule

// File: rtl/cfg_xlate_bridge_chk.sv
module cfg_xlate_bridge_chk
  import cfgx_pkg::*;
#(
  parameter int WIN_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              h_req,
  input logic [WIN_BITS:0] h_addr,
  input logic              h_we,
  input logic [1:0]        h_size,
  input logic              t_valid,
  input logic              t_ready,
  input logic [CFG_W-1:0]  t_addr,
  input logic [LANES-1:0]  t_be,
  input logic [CFG_W-1:0]  idx_q,
  input logic              idx_ack,
  input logic              dat_ack
);

  // R10: request held stable while the target stalls
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && !t_ready) |=> (t_valid && $stable(t_addr) && $stable(t_be)));

  // R10: a data completion follows a handshake in the previous cycle
  a_r10_done_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ack |-> $past(t_valid && t_ready));

  // R11: index completion never overlaps a target request
  a_r11_idx_no_target: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ack |-> (!t_valid && $past(!t_valid)));

  // R2 / R3: index changes only after a full-width index-window write
  a_r3_idx_full_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(idx_q) |-> $past(h_req && !h_addr[WIN_BITS] && h_we && h_size[1]));

  // R8: lane enables are one, two or four lanes
  a_r8_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
    t_valid |-> ($countones(t_be) == 1 || $countones(t_be) == 2 ||
                 $countones(t_be) == 4));

  // R4: pass-through keeps the upper address bits
  a_r4_raw_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && idx_q[31]) |-> (t_addr[31:2] == idx_q[31:2]));

  // R7: no IDSEL bit set gives an all-ones device field
  a_r7_no_idsel: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && !idx_q[31] && !idx_q[0] && (idx_q[31:11] == 21'd0))
      |-> (t_addr[31:11] == 21'h1F_FFFF));

endmodule

bind cfg_xlate_bridge cfg_xlate_bridge_chk #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .h_req   (h_req),
  .h_addr  (h_addr),
  .h_we    (h_we),
  .h_size  (h_size),
  .t_valid (t_valid),
  .t_ready (t_ready),
  .t_addr  (t_addr),
  .t_be    (t_be),
  .idx_q   (idx_q),
  .idx_ack (idx_ack),
  .dat_ack (dat_ack)
);

// File: tb/cfg_xlate_bridge_bench.sv
module cfg_xlate_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_req = 1'b0;
  logic [12:0] h_addr = '0;
  logic        h_we = 1'b0;
  logic [1:0]  h_size = '0;
  logic [31:0] h_wdata = '0;
  logic [31:0] h_rdata;
  logic        h_done;
  logic        t_valid;
  logic        t_ready = 1'b0;
  logic [31:0] t_addr;
  logic [3:0]  t_be;
  logic        t_we;
  logic [31:0] t_wdata;
  logic [31:0] t_rdata = '0;

  int checks = 0;
  int fails  = 0;
  bit data_busy = 1'b0;
  bit finished  = 1'b0;

  int          tgt_lat = 0;
  int          tgt_cnt = 0;
  logic [31:0] rd_pat = '0;
  bit          cap_seen;
  logic [31:0] cap_addr, cap_wdata;
  logic [3:0]  cap_be;
  logic        cap_we;
  logic [31:0] exp_idx = 32'h0;

  always #5 clk = ~clk;

  cfg_xlate_bridge u_cfg_xlate_bridge (
    .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_addr(h_addr), .h_we(h_we),
    .h_size(h_size), .h_wdata(h_wdata), .h_rdata(h_rdata), .h_done(h_done),
    .t_valid(t_valid), .t_ready(t_ready), .t_addr(t_addr), .t_be(t_be),
    .t_we(t_we), .t_wdata(t_wdata), .t_rdata(t_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Reference translation, written from the requirements.
  function automatic logic [31:0] ref_addr(input logic [31:0] idx, input int off);
    int dev;
    if (idx[31]) return (idx & 32'hFFFF_FFFC) | 32'(off % 4);
    if (idx[0])  return (idx & 32'hFFFF_FFF8) | 32'(off % 8);
    dev = -1;
    for (int b = 11; b < 32; b++) if (idx[b] && dev < 0) dev = b;
    if (dev < 0) return 32'hFFFF_F800 | (idx & 32'h0000_07F8) | 32'(off % 8);
    return (32'(dev) << 11) | (idx & 32'h0000_07F8) | 32'(off % 8);
  endfunction

  function automatic logic [3:0] ref_be(input int sz, input int off);
    if (sz == 0) return 4'(1 << (off % 4));
    if (sz == 1) return ((off % 4) >= 2) ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  // Target model: responds after tgt_lat cycles of valid.
  always @(negedge clk) begin
    if (t_ready) begin
      t_ready <= 1'b0;
      tgt_cnt <= 0;
    end else if (t_valid) begin
      if (tgt_cnt == tgt_lat) begin
        t_ready   <= 1'b1;
        t_rdata   <= rd_pat;
        cap_seen  <= 1'b1;
        cap_addr  <= t_addr;
        cap_be    <= t_be;
        cap_we    <= t_we;
        cap_wdata <= t_wdata;
      end else begin
        tgt_cnt <= tgt_cnt + 1;
      end
    end
  end

  // Per-clock comparison of the request line against the model state (R11).
  always @(negedge clk) begin
    if (rst_n && !finished) chk("R11 t_valid outside data access", 32'(t_valid && !data_busy), 32'h0);
  end

  task automatic acc(input bit data, input int off, input bit we, input int sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    cap_seen  = 1'b0;
    data_busy = data;
    h_req   = 1'b1;
    h_addr  = {data, 12'(off)};
    h_we    = we;
    h_size  = 2'(sz);
    h_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!h_done);
    rd    = h_rdata;
    h_req = 1'b0;
    if (!data && we && sz >= 2) exp_idx = wd;
    @(negedge clk);
    data_busy = 1'b0;
  endtask

  task automatic data_case(input string tag, input logic [31:0] idx, input int off,
                           input bit we, input int sz, input logic [31:0] wd, input int lat);
    logic [31:0] rd;
    int cyc;
    acc(1'b0, 0, 1'b1, 2, idx, rd, cyc);
    tgt_lat = lat;
    rd_pat  = wd ^ 32'h5A5A_A5A5;
    acc(1'b1, off, we, sz, wd, rd, cyc);
    chk({tag, " addr"}, cap_addr, ref_addr(idx, off));
    chk("R8 byte enables", {28'h0, cap_be}, {28'h0, ref_be(sz, off)});
    chk("R9 direction", {31'h0, cap_we}, {31'h0, we});
    if (we) chk("R9 write data", cap_wdata, wd);
    else    chk("R9 read data", rd, wd ^ 32'h5A5A_A5A5);
    chk("R10 handshake seen", {31'h0, cap_seen}, 32'h1);
    chk("R10 latency", 32'(cyc), 32'(lat + 2));
  endtask

  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    chk("R1 t_valid in reset", {31'h0, t_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    acc(1'b0, 0, 1'b0, 2, 32'h0, rd, cyc);
    chk("R1 index after reset", rd, 32'h0);
    chk("R11 index latency", 32'(cyc), 32'h1);

    acc(1'b0, 0, 1'b1, 2, 32'h8000_1234, rd, cyc);
    acc(1'b0, 0, 1'b0, 2, 32'h0, rd, cyc);
    chk("R2 index readback", rd, 32'h8000_1234);
    acc(1'b0, 0, 1'b1, 3, 32'h8765_4320, rd, cyc);
    acc(1'b0, 0, 1'b0, 0, 32'h0, rd, cyc);
    chk("R2 size-3 write", rd, 32'h8765_4320);
    acc(1'b0, 0, 1'b1, 1, 32'h0000_FFFF, rd, cyc);
    acc(1'b0, 0, 1'b1, 0, 32'h0000_00FF, rd, cyc);
    acc(1'b0, 0, 1'b0, 2, 32'h0, rd, cyc);
    chk("R3 narrow writes ignored", rd, exp_idx);

    data_case("R4", 32'h8000_1234, 6, 1'b0, 1, 32'h1122_3344, 0);
    data_case("R4", 32'hC0FF_EE03, 3, 1'b1, 0, 32'hAB00_0000, 3);
    data_case("R5", 32'h00AB_CD01, 5, 1'b1, 0, 32'h0000_EE00, 1);
    data_case("R5", 32'h1234_5677, 2, 1'b0, 2, 32'hDEAD_BEEF, 0);
    data_case("R6", 32'h0000_2340, 2, 1'b0, 1, 32'h0BAD_F00D, 2);
    data_case("R6", 32'h0210_0578, 7, 1'b1, 0, 32'h7700_0000, 0);
    data_case("R6", 32'h4000_0000, 0, 1'b0, 3, 32'h0F0F_0F0F, 5);
    data_case("R7", 32'h0000_0728, 4, 1'b0, 2, 32'hCAFE_0001, 1);
    data_case("R7", 32'h0000_0000, 1, 1'b1, 0, 32'h0000_4400, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule